// File: doc/BRIEF.md
# DDR Read Strobe and Data Output Sequencer

This block is the output side of a DDR memory device's read path. It takes a read command together with the full burst of data words and, after a fixed read latency, produces the data strobe and data lines at half-clock resolution. For each clock it gives a drive enable and a value for each half of the clock, on both the strobe and the data bus. The next stage can then turn these into a real tri-state pad, and a testbench can compare them with an expected released/low/high pattern.

A burst that starts from an idle bus is preceded by one clock of strobe held low. During the burst the strobe goes high in the first half of each clock and low in the second half, with one data word in each half. After the last data clock the strobe is held low for one half clock and then released. A read whose command comes exactly one burst length after the previous one is joined to it with no gap. A whole chain of such reads therefore carries a single preamble and a single postamble. Reads at other spacings that would collide with a stream in progress are held in one waiting slot and started after the bus is free.

Top module: `dqs_read_seq`

## Requirements
- R1: While reset is asserted, and whenever no stream is active, all four outputs are zero: nothing is driven and all values are 0.
- R2: A read that starts on an idle bus produces, in the clock RD_LAT-1 clocks after its command clock, a preamble clock. In that clock dqs_oe=2'b11, dqs_o=2'b00 and dq_oe=2'b00.
- R3: A read's first data clock is RD_LAT clocks after its command clock (when it is not delayed by R6 or R7), and it is followed by BL-1 further data clocks. Every data clock has dqs_oe=2'b11, dqs_o=2'b01 (bit 0 is the first half), dq_oe=2'b11, and dq_o carrying words 2k (bits W-1:0) and 2k+1 (bits 2W-1:W) in its k-th data clock. Word j of a burst is rd_data[j*W +: W].
- R4: The clock after the last data clock of a stream is a postamble clock: dqs_oe=2'b01, dqs_o=2'b00, dq_oe=2'b00. It lasts exactly one clock.
- R5: A read whose command clock is exactly BL clocks after the previous read of a running stream continues that stream. Its data clocks follow the previous data clocks directly, with no preamble and no postamble between them.
- R6: A read that is not seamless and whose launch clock (RD_LAT-2 clocks after its command) falls on a preamble or data clock of a stream is held. Its preamble comes in the clock right after that stream's postamble clock.
- R7: A read whose launch clock falls on a postamble clock is held. One fully released clock follows, then its preamble.
- R8: Only one read can be held. A read whose launch clock comes while another read is held is discarded and never appears on the data lines.
- R9: Asserting the active-low asynchronous reset releases all outputs at once and discards every read in flight or held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read command, sampled on the rising edge |
| rd_data | input | 2*BL*W | Burst words, word j at bits j*W +: W |
| dqs_oe | output | 2 | Strobe drive enable per half clock (bit 0 first half) |
| dqs_o | output | 2 | Strobe value per half clock |
| dq_oe | output | 2 | Data drive enable per half clock |
| dq_o | output | 2*W | Data per half clock, first half in bits W-1:0 |

## Verification
The bench goes after the spacing of a second read relative to the first. It covers every gap from inside the preamble, through each data clock and the postamble, to a fully idle bus, and it adds a three-read seamless chain and a read landing while a joined read is being taken over. A sequencer that gets the join timing wrong either inserts a stray preamble into a seamless chain or runs two strobe drivers over each other. One that mishandles a late read starts its preamble on top of the postamble half clock, or loses the read. The bench also checks that a second waiting read is dropped rather than overwriting the first, and that reset in mid-burst silences the lines with nothing resuming afterwards.

// File: rtl/dqs_read_seq.sv
module dqs_read_seq #(
  parameter int BL     = 4,
  parameter int W      = 8,
  parameter int RD_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [2*BL*W-1:0] rd_data,
  output logic [1:0]        dqs_oe,
  output logic [1:0]        dqs_o,
  output logic [1:0]        dq_oe,
  output logic [2*W-1:0]    dq_o
);
  localparam int DW = 2 * W;
  localparam int BW = BL * DW;
  localparam int D  = RD_LAT - 2;
  localparam int CW = $clog2(BL + 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DAT, S_POST} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] sh, hd;
  logic          hv, hc;
  logic          launch;
  logic [BW-1:0] ldata;

  if (D == 0) begin : g_nodly
    assign launch = rd_valid;
    assign ldata  = rd_data;
  end else begin : g_dly
    logic [D-1:0]  dly_v;
    logic [BW-1:0] dly_d [D];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dly_v <= '0;
        for (int i = 0; i < D; i++) dly_d[i] <= '0;
      end else begin
        dly_v[0] <= rd_valid;
        dly_d[0] <= rd_data;
        for (int i = 1; i < D; i++) begin
          dly_v[i] <= dly_v[i-1];
          dly_d[i] <= dly_d[i-1];
        end
      end
    end
    assign launch = dly_v[D-1];
    assign ldata  = dly_d[D-1];
  end

  wire last_dat = (st == S_DAT) && (cnt == CW'(1));
  wire chain    = (st == S_DAT) && (cnt == CW'(2));
  wire consume  = hv && ((st == S_IDLE) || (st == S_POST) || (last_dat && hc));
  wire take_new = launch && (st == S_IDLE) && !hv;
  wire store    = launch && !take_new && (!hv || consume);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      sh  <= '0;
      hd  <= '0;
      hv  <= 1'b0;
      hc  <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (hv) begin
            st <= S_PRE; sh <= hd; hv <= 1'b0;
          end else if (launch) begin
            st <= S_PRE; sh <= ldata;
          end
        S_PRE: begin
          st  <= S_DAT;
          cnt <= CW'(BL);
        end
        S_DAT:
          if (!last_dat) begin
            cnt <= cnt - CW'(1);
            sh  <= sh >> DW;
          end else if (hv && hc) begin
            cnt <= CW'(BL); sh <= hd; hv <= 1'b0;
          end else begin
            st <= S_POST;
          end
        S_POST:
          if (hv) begin
            st <= S_PRE; sh <= hd; hv <= 1'b0;
          end else begin
            st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
      if (store) begin
        hv <= 1'b1;
        hc <= chain;
        hd <= ldata;
      end
    end
  end

  assign dqs_oe = (st == S_PRE || st == S_DAT) ? 2'b11 : (st == S_POST) ? 2'b01 : 2'b00;
  assign dqs_o  = (st == S_DAT) ? 2'b01 : 2'b00;
  assign dq_oe  = (st == S_DAT) ? 2'b11 : 2'b00;
  assign dq_o   = (st == S_DAT) ? sh[DW-1:0] : '0;

  p_dq_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != 2'b00) |-> (dqs_oe == 2'b11 && dqs_o == 2'b01));

  p_preamble_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe[0]) |-> ($past(dqs_oe) == 2'b11 && $past(dqs_o) == 2'b00));

  p_postamble_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe[0]) |-> (dqs_oe == 2'b01 && dqs_o == 2'b00 && dq_oe == 2'b00));

  p_postamble_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POST) |=> (st != S_POST));

  p_seamless_join_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && chain && !hv) |=> ##1 (st == S_DAT && cnt == CW'(BL)));

  p_late_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && st == S_DAT && !chain && !hv) |=> hv);
endmodule

// File: tb/dqs_read_seq_test.sv
`timescale 1ns/1ps
module dqs_read_seq_test;
  localparam int BL = 4, W = 8, RL = 4, NW = 2 * BL, NC = 26;

  logic              clk = 1'b0, rst_n = 1'b0, rd_valid = 1'b0;
  logic [NW*W-1:0]   rd_data = '0;
  logic [1:0]        dqs_oe, dqs_o, dq_oe;
  logic [2*W-1:0]    dq_o;

  int total = 0, bad = 0;
  int ecode [NC];
  logic [7:0] ew0 [NC], ew1 [NC];

  always #2.5 clk = ~clk;

  dqs_read_seq #(.BL(BL), .W(W), .RD_LAT(RL)) uut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_data(rd_data),
    .dqs_oe(dqs_oe), .dqs_o(dqs_o), .dq_oe(dq_oe), .dq_o(dq_o));

  // gap1, gap2 (0 = none), data start of 2nd burst, its preamble, data start of 3rd, its preamble
  localparam int VEC [10][6] = '{
    '{4, 0,  8, 0,  0, 0},   // R5 seamless pair
    '{5, 0, 10, 1,  0, 0},   // R6 launch on last data clock
    '{6, 0, 11, 1,  0, 0},   // R7 launch on postamble clock
    '{7, 0, 11, 1,  0, 0},   // R2 idle bus again
    '{3, 0, 10, 1,  0, 0},   // R6 mid burst
    '{1, 0, 10, 1,  0, 0},   // R6 during preamble
    '{8, 0, 12, 1,  0, 0},   // R2 well separated
    '{4, 8,  8, 0, 12, 0},   // R5 three-read chain
    '{2, 3, 10, 1,  0, 0},   // R8 second waiting read dropped
    '{4, 5,  8, 0, 14, 1}    // R6 read arriving as joined read is taken over
  };

  function automatic string tag_of(int i);
    case (i)
      0, 7:       return "R5";
      2:          return "R7";
      3, 6:       return "R2";
      8:          return "R8";
      default:    return "R6";
    endcase
  endfunction

  function automatic logic [7:0] wd(int s, int b, int j);
    return 8'((s * 37 + b * 11 + j * 3 + 5) & 255);
  endfunction

  function automatic string req_of(int code);
    case (code)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic check_cycle(int c, int code, string tag, int scn);
    logic [21:0] got, exp;
    got = {dqs_oe, dqs_o, dq_oe, dq_o};
    case (code)
      1: exp = {2'b11, 2'b00, 2'b00, 16'h0};
      2: exp = {2'b11, 2'b01, 2'b11, ew1[c], ew0[c]};
      3: exp = {2'b01, 2'b00, 2'b00, 16'h0};
      default: exp = 22'h0;
    endcase
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s/%s scn=%0d cyc=%0d got=%h exp=%h", req_of(code), tag, scn, c, got, exp);
    end
  endtask

  task automatic add_burst(int scn, int b, int s, int pre);
    if (pre != 0) ecode[s-1] = 1;
    for (int k = 0; k < BL; k++) begin
      ecode[s+k] = 2;
      ew0[s+k] = wd(scn, b, 2*k);
      ew1[s+k] = wd(scn, b, 2*k+1);
    end
  endtask

  task automatic run_scn(int scn);
    int g1, g2, b;
    g1 = VEC[scn][0];
    g2 = VEC[scn][1];
    for (int c = 0; c < NC; c++) begin ecode[c] = 0; ew0[c] = 0; ew1[c] = 0; end
    add_burst(scn, 0, RL, 1);
    if (VEC[scn][2] != 0) add_burst(scn, 1, VEC[scn][2], VEC[scn][3]);
    if (VEC[scn][4] != 0) add_burst(scn, 2, VEC[scn][4], VEC[scn][5]);
    for (int c = 1; c < NC; c++)
      if (ecode[c-1] == 2 && ecode[c] == 0) ecode[c] = 3;
    for (int c = 0; c < NC; c++) begin
      @(negedge clk);
      check_cycle(c, ecode[c], tag_of(scn), scn);
      b = (c == 0) ? 0 : (c == g1) ? 1 : (g2 != 0 && c == g2) ? 2 : -1;
      rd_valid = (b >= 0);
      for (int j = 0; j < NW; j++) rd_data[j*W +: W] = (b >= 0) ? wd(scn, b, j) : 8'h0;
    end
  endtask

  task automatic check_idle(string tag);
    total++;
    if ({dqs_oe, dqs_o, dq_oe, dq_o} !== 22'h0) begin
      bad++;
      $display("FAIL %s got=%h exp=0", tag, {dqs_oe, dqs_o, dq_oe, dq_o});
    end
  endtask

  initial begin
    repeat (1500) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: held in reset with a read request present
    rd_valid = 1'b1;
    rd_data = '1;
    repeat (3) begin @(negedge clk); check_idle("R1 in reset"); end
    rd_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (8) begin @(negedge clk); check_idle("R1 after reset"); end

    for (int s = 0; s < 10; s++) run_scn(s);

    // R9: reset in the middle of a burst with a second read waiting
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      rd_valid = (c == 0 || c == 2);
      rd_data = rd_valid ? {NW{8'hA5}} : '0;
    end
    rd_valid = 1'b0;
    @(negedge clk);
    total++;
    if (dq_oe !== 2'b11) begin
      bad++;
      $display("FAIL R3 pre-reset burst not running got=%b exp=11", dq_oe);
    end
    #0.5 rst_n = 1'b0;
    #0.5 check_idle("R9 immediate release");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) begin @(negedge clk); check_idle("R9 nothing resumes"); end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule